// File: doc/BRIEF.md
# Pipelined Sample-and-Convert Scheduler

This block sequences one successive-approximation converter that is fed by two sample-and-hold stages. Conversion requests enter through a ready/valid port and wait in a short queue. Each request carries a channel tag, an acquisition-window length and a flag that selects dual-stage sampling. The scheduler drives the hold-switch enables and flags the conversion phase. It latches the digital sample word that stands at the stage input at the end of each window. After the fixed conversion latency it emits that word together with its tag. The analog front end is modelled as two digital input words.

The throughput comes from overlap. A conversion holds its sample stage for its first six clocks. After that, the stage is free, and the next queued window may open while the current conversion runs to its end. With the minimum window of seven clocks, this makes conversions run back to back. Each extra clock of window delays the following conversion by one clock. In dual-stage mode both stages close together for one window. Their two words are then converted one after the other, and the next window waits for the second conversion to release its stage. A request that arrives while the block is idle gets no overlap.

Top module: `adc_sample_scheduler`

## Requirements
- R1: The effective window is the requested 6-bit length, raised to 7 when it is below 7. The hold enables stay high for exactly that many consecutive clocks. `holdEn[0]` (stage A) is used for every request. `holdEn[1]` (stage B) is also raised for dual-stage requests only.
- R2: The word captured for a stage is the value on its sample input during the last clock of the window, and that same word is delivered as `resData`.
- R3: The result for stage A pulses `resValid` for one clock, exactly 13 clocks after the last window clock.
- R4: When a request is waiting, its window opens exactly 6 clocks after the start of the conversion that last occupied a stage, and no earlier. A 7-clock window therefore yields results spaced 13 clocks apart, and a window of 7+k clocks spaces them 13+k apart.
- R5: From idle, a request accepted in clock t opens its window in clock t+2.
- R6: A dual-stage request delivers two results with the same tag: `resLane`=0 (stage A) 13 clocks after the window, then `resLane`=1 (stage B) 26 clocks after it. The next window opens no earlier than 6 clocks after the stage-B conversion starts.
- R7: Results leave in request order, each carrying the tag of its request. Single-stage results have `resLane`=0.
- R8: The queue holds 4 requests. `reqReady` is low while 4 are held, and a full queue loses no entry.
- R9: A synchronous reset opens both hold switches and clears `resValid`, `convBusy` and the queue. Requests queued before reset never produce a window or a result.
- R10: `convBusy` is high exactly in the 13 clocks of each conversion, or the 26 clocks of a dual-stage pair, beginning the clock after the window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Queue can take a request |
| reqTag | input | TAG_W | Channel tag of the request |
| reqWin | input | WIN_W | Requested window length in clocks |
| reqSimul | input | 1 | 1 = sample both stages together |
| sampleA | input | DATA_W | Digital stand-in for stage A input |
| sampleB | input | DATA_W | Digital stand-in for stage B input |
| holdEn | output | 2 | Hold-switch enables, bit 0 stage A, bit 1 stage B |
| convBusy | output | 1 | Converter running |
| resValid | output | 1 | One-clock result strobe |
| resTag | output | TAG_W | Tag of the result |
| resLane | output | 1 | 0 = stage A word, 1 = stage B word |
| resData | output | DATA_W | Converted word |

## Verification
The two functions that can fall in the same clock are the end of a window and the end of the preceding conversion. With a backlog of 7-clock windows, the latch of the new sample and the start of its conversion share a clock with the old result's strobe. This also happens after a dual-stage pair ends. Back-to-back request bursts provoke the case. A scoreboard judges it: for every window it predicts the exact opening clock from the hold-release rule, it records the sampled word and it demands each result on its exact due clock. A lost or a shifted result in that shared clock is therefore caught.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

  // Number of sample-and-hold stages feeding the converter.
  localparam int NUM_STAGES = 2;

  // Strobes handed from the sequencer to the datapath each clock.
  typedef struct packed {
    logic popWin;    // request leaves the queue, window opens next clock
    logic capture;   // last clock of a window: latch the stage words
    logic captureB;  // stage B takes part in this capture
    logic loadSar;   // a conversion starts next clock
    logic sarLane;   // which stage that conversion reads
    logic emit;      // last clock of a conversion: result is valid
  } ctlStrobe_t;

endpackage

// File: rtl/adc_req_fifo.sv
module adc_req_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 11,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [WIDTH-1:0] wrData,
  output logic             rdValid,
  input  logic             rdPop,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doPush;
  logic             doPop;

  assign wrReady = (count != CNT_FULL);
  assign rdValid = (count != '0);
  assign rdData  = slots[rdPtr];
  assign doPush  = wrValid && wrReady;
  assign doPop   = rdPop && rdValid;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/adc_sched_ctl.sv
module adc_sched_ctl
  import adc_sched_pkg::*;
#(
  parameter int WIN_W    = 6,
  parameter int MIN_WIN  = 7,
  parameter int CONV_CYC = 13,
  parameter int HOLD_CYC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qValid,
  input  logic [WIN_W-1:0] qWin,
  input  logic             qSimul,
  output logic             qPop,
  output ctlStrobe_t       strobe,
  output logic [1:0]       holdEn,
  output logic             convBusy
);

  localparam int CONV_W = $clog2(CONV_CYC + 1);
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYC - 1);
  localparam logic [CONV_W-1:0] HOLD_GATE = CONV_W'(HOLD_CYC - 1);
  localparam logic [WIN_W-1:0]  WIN_FLOOR = WIN_W'(MIN_WIN);

  // Acquisition sequencer state
  logic             winActive;
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] winLen;
  logic             winSimul;

  // Converter sequencer state
  logic              convActive;
  logic [CONV_W-1:0] convCnt;
  logic              pendB;

  logic             winLast;
  logic             convEnd;
  logic             stageFree;
  logic             startWin;
  logic [WIN_W-1:0] effWin;

  always_comb begin
    winLast   = winActive && (winCnt == winLen - 1'b1);
    convEnd   = convActive && (convCnt == CONV_LAST);
    // A stage is free once no window is open, no second word waits,
    // and the running conversion is past its hold-tied clocks.
    stageFree = !winActive && !pendB && (!convActive || (convCnt >= HOLD_GATE));
    startWin  = qValid && stageFree;
    effWin    = (qWin < WIN_FLOOR) ? WIN_FLOOR : qWin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winActive <= 1'b0;
      winCnt    <= '0;
      winLen    <= WIN_FLOOR;
      winSimul  <= 1'b0;
    end else if (startWin) begin
      winActive <= 1'b1;
      winCnt    <= '0;
      winLen    <= effWin;
      winSimul  <= qSimul;
    end else if (winLast) begin
      winActive <= 1'b0;
      winCnt    <= '0;
    end else if (winActive) begin
      winCnt    <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      convActive <= 1'b0;
      convCnt    <= '0;
      pendB      <= 1'b0;
    end else if (winLast) begin
      convActive <= 1'b1;
      convCnt    <= '0;
      pendB      <= winSimul;
    end else if (convEnd) begin
      convCnt <= '0;
      if (pendB) begin
        pendB <= 1'b0;
      end else begin
        convActive <= 1'b0;
      end
    end else if (convActive) begin
      convCnt <= convCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.popWin   = startWin;
    strobe.capture  = winLast;
    strobe.captureB = winLast && winSimul;
    strobe.loadSar  = winLast || (convEnd && pendB);
    strobe.sarLane  = !winLast;
    strobe.emit     = convEnd;
  end

  assign qPop     = startWin;
  assign holdEn   = {winActive && winSimul, winActive};
  assign convBusy = convActive;

endmodule

// File: rtl/adc_sched_dp.sv
module adc_sched_dp
  import adc_sched_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [TAG_W-1:0]  qTag,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic              resLane,
  output logic [DATA_W-1:0] resData
);

  logic [DATA_W-1:0] stageIn  [NUM_STAGES];
  logic [DATA_W-1:0] holdReg  [NUM_STAGES];
  logic [TAG_W-1:0]  winTag;
  logic [TAG_W-1:0]  holdTag;
  logic [DATA_W-1:0] sarWord;
  logic [TAG_W-1:0]  convTag;
  logic              convLane;
  logic [DATA_W-1:0] sarSrc;
  logic [TAG_W-1:0]  tagSrc;

  assign stageIn[0] = sampleA;
  assign stageIn[1] = sampleB;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
    localparam bit PRIMARY = (g == 0);
    logic takeIt;
    assign takeIt = strobe.capture && (PRIMARY || strobe.captureB);
    always_ff @(posedge clk) begin
      if (rst)         holdReg[g] <= '0;
      else if (takeIt) holdReg[g] <= stageIn[g];
    end
  end

  // A conversion starting on the capture clock reads the live word;
  // the deferred second conversion reads the held stage B word.
  always_comb begin
    sarSrc = strobe.capture ? stageIn[0] : holdReg[strobe.sarLane];
    tagSrc = strobe.capture ? winTag : holdTag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winTag   <= '0;
      holdTag  <= '0;
      sarWord  <= '0;
      convTag  <= '0;
      convLane <= 1'b0;
    end else begin
      if (strobe.popWin)  winTag  <= qTag;
      if (strobe.capture) holdTag <= winTag;
      if (strobe.loadSar) begin
        sarWord  <= sarSrc;
        convTag  <= tagSrc;
        convLane <= strobe.sarLane;
      end
    end
  end

  assign resValid = strobe.emit;
  assign resTag   = convTag;
  assign resLane  = convLane;
  assign resData  = sarWord;

endmodule

// File: rtl/adc_sample_scheduler.sv
module adc_sample_scheduler
  import adc_sched_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int TAG_W      = 4,
  parameter int WIN_W      = 6,
  parameter int MIN_WIN    = 7,
  parameter int CONV_CYC   = 13,
  parameter int HOLD_CYC   = 6,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [WIN_W-1:0]  reqWin,
  input  logic              reqSimul,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  output logic [1:0]        holdEn,
  output logic              convBusy,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic              resLane,
  output logic [DATA_W-1:0] resData
);

  localparam int REQ_W = TAG_W + WIN_W + 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [REQ_W-1:0] fifoOut;
  logic             fifoValid;
  logic             fifoPop;
  logic [CNT_W-1:0] fifoCount;
  ctlStrobe_t       strobe;

  adc_req_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(REQ_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wrValid (reqValid),
    .wrReady (reqReady),
    .wrData  ({reqTag, reqWin, reqSimul}),
    .rdValid (fifoValid),
    .rdPop   (fifoPop),
    .rdData  (fifoOut),
    .count   (fifoCount)
  );

  adc_sched_ctl #(
    .WIN_W(WIN_W), .MIN_WIN(MIN_WIN), .CONV_CYC(CONV_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .qValid   (fifoValid),
    .qWin     (fifoOut[WIN_W:1]),
    .qSimul   (fifoOut[0]),
    .qPop     (fifoPop),
    .strobe   (strobe),
    .holdEn   (holdEn),
    .convBusy (convBusy)
  );

  adc_sched_dp #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .qTag     (fifoOut[REQ_W-1:WIN_W+1]),
    .sampleA  (sampleA),
    .sampleB  (sampleB),
    .resValid (resValid),
    .resTag   (resTag),
    .resLane  (resLane),
    .resData  (resData)
  );

endmodule

// File: rtl/adc_sched_checker.sv
module adc_sched_checker #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reqReady,
  input logic [1:0]       holdEn,
  input logic             convBusy,
  input logic             resValid,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoPop
);

  // R9: the clock after a reset edge shows closed switches and no activity
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (holdEn == 2'b00 && !resValid && !convBusy));

  // R3: a result strobe only appears inside a conversion
  assert_result_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
    resValid |-> convBusy);

  // R10: a window closing hands straight over to a running conversion
  assert_conv_follows_window_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(holdEn[0]) && !$past(rst)) |-> convBusy);

  // R6: stage B never samples on its own
  assert_stage_b_paired_R6: assert property (@(posedge clk) disable iff (rst)
    holdEn[1] |-> holdEn[0]);

  // R8: a full queue that is not drained stays full and closed
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fifoCount) == CNT_W'(DEPTH) && !$past(fifoPop))
      |-> (fifoCount == CNT_W'(DEPTH) && !reqReady));

endmodule

bind adc_sample_scheduler adc_sched_checker #(.DEPTH(FIFO_DEPTH)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .reqReady  (reqReady),
  .holdEn    (holdEn),
  .convBusy  (convBusy),
  .resValid  (resValid),
  .fifoCount (fifoCount),
  .fifoPop   (fifoPop)
);

// File: tb/tb_adc_sample_scheduler.sv
`timescale 1ns/1ps
module tb_adc_sample_scheduler;

  localparam int DATA_W = 12;
  localparam int TAG_W  = 4;
  localparam int WIN_W  = 6;

  typedef struct { int tag; int win; int simul; int acc; } reqItem_t;
  typedef struct { int tag; int lane; int data; int due; } expItem_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [TAG_W-1:0]  reqTag = '0;
  logic [WIN_W-1:0]  reqWin = '0;
  logic              reqSimul = 1'b0;
  logic [DATA_W-1:0] sampleA = '0;
  logic [DATA_W-1:0] sampleB = '0;
  logic [1:0]        holdEn;
  logic              convBusy;
  logic              resValid;
  logic [TAG_W-1:0]  resTag;
  logic              resLane;
  logic [DATA_W-1:0] resData;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  reqItem_t reqQ[$];
  expItem_t expQ[$];

  adc_sample_scheduler dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqTag(reqTag), .reqWin(reqWin), .reqSimul(reqSimul),
    .sampleA(sampleA), .sampleB(sampleB), .holdEn(holdEn),
    .convBusy(convBusy), .resValid(resValid), .resTag(resTag),
    .resLane(resLane), .resData(resData)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Stage inputs change every clock so each capture clock is distinguishable
  initial forever begin
    @(posedge clk); #1;
    sampleA = DATA_W'(cyc * 37 + 5);
    sampleB = DATA_W'(cyc * 91 + 1000);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int effWin(input int w);
    return (w < 7) ? 7 : w;
  endfunction

  // Driver: call just after a rising edge; returns just after a rising edge
  task automatic push(input int tag, input int win, input int simul);
    reqItem_t it;
    reqValid = 1'b1;
    reqTag   = TAG_W'(tag);
    reqWin   = WIN_W'(win);
    reqSimul = simul[0];
    do @(negedge clk); while (!reqReady);
    it.tag = tag; it.win = win; it.simul = simul; it.acc = cyc;
    reqQ.push_back(it);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (reqQ.size() != 0 || expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // Monitor and scoreboard
  bit [1:0]    prevHold = 2'b00;
  int          prevA = 0;
  int          prevB = 0;
  int          releaseAt = 0;
  int          busyFrom = 1;
  int          busyTo = 0;
  int          winStart = 0;
  int          winSeen = 0;
  reqItem_t    cur;
  expItem_t    head;
  expItem_t    e;

  always @(negedge clk) begin
    if (rst) begin
      reqQ.delete();
      expQ.delete();
      prevHold  = 2'b00;
      releaseAt = 0;
      busyFrom  = 1;
      busyTo    = 0;
    end else begin
      // window opening
      if (holdEn[0] && !prevHold[0]) begin
        winSeen++;
        if (reqQ.size() == 0) begin
          chk(1'b0, "R9", "window with no request", 1, 0);
        end else begin
          int expStart;
          cur = reqQ.pop_front();
          expStart = (cur.acc + 2 > releaseAt) ? cur.acc + 2 : releaseAt;
          if (releaseAt > cur.acc + 2)
            chk(cyc == expStart, "R4", "window open after hold release", cyc, expStart);
          else
            chk(cyc == expStart, "R5", "window open from idle", cyc, expStart);
          chk(holdEn == (cur.simul ? 2'b11 : 2'b01), cur.simul ? "R6" : "R1",
              "hold enables", int'(holdEn), cur.simul ? 3 : 1);
          winStart = cyc;
        end
      end
      // window closing: last window clock was cyc-1
      if (!holdEn[0] && prevHold[0]) begin
        int last;
        last = cyc - 1;
        chk(cyc - winStart == effWin(cur.win), "R1", "window length",
            cyc - winStart, effWin(cur.win));
        e.tag = cur.tag; e.lane = 0; e.data = prevA; e.due = last + 13;
        expQ.push_back(e);
        if (cur.simul != 0) begin
          e.lane = 1; e.data = prevB; e.due = last + 26;
          expQ.push_back(e);
        end
        busyFrom  = last + 1;
        busyTo    = last + ((cur.simul != 0) ? 26 : 13);
        releaseAt = last + 1 + ((cur.simul != 0) ? 13 : 0) + 6;
      end
      // conversion phase flag
      chk(convBusy == (cyc >= busyFrom && cyc <= busyTo), "R10", "convBusy",
          int'(convBusy), int'(cyc >= busyFrom && cyc <= busyTo));
      // results
      if (resValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7", "unexpected result", int'(resTag), -1);
        end else begin
          head = expQ.pop_front();
          chk(cyc == head.due, (head.lane != 0) ? "R6" : "R3", "result clock", cyc, head.due);
          chk(int'(resTag) == head.tag, "R7", "result tag", int'(resTag), head.tag);
          chk(int'(resLane) == head.lane, "R6", "result lane", int'(resLane), head.lane);
          chk(int'(resData) == head.data, "R2", "result word", int'(resData), head.data);
        end
      end else if (expQ.size() != 0 && expQ[0].due <= cyc) begin
        head = expQ.pop_front();
        chk(1'b0, "R3", "missing result", cyc, head.due);
      end
    end
    prevHold = holdEn;
    prevA    = int'(sampleA);
    prevB    = int'(sampleB);
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seenBefore;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(holdEn == 2'b00, "R9", "holdEn after reset", int'(holdEn), 0);
    chk(!resValid, "R9", "resValid after reset", int'(resValid), 0);
    chk(!convBusy, "R9", "convBusy after reset", int'(convBusy), 0);
    chk(reqReady, "R9", "reqReady after reset", int'(reqReady), 1);
    @(posedge clk); #1;

    // single request from idle (R5, R1, R2, R3)
    push(1, 7, 0);
    drain();

    // back-to-back minimum windows: overlap (R4), capture beside emit
    push(2, 7, 0); push(3, 7, 0); push(4, 7, 0); push(5, 7, 0);
    drain();

    // short windows raised to the floor (R1)
    push(6, 2, 0); push(7, 0, 0);
    drain();

    // longer windows delay the following conversion (R4)
    push(8, 10, 0); push(9, 20, 0); push(10, 7, 0);
    drain();

    // dual-stage mixed with single-stage (R6, R7)
    push(11, 7, 1); push(12, 7, 0); push(13, 9, 1); push(14, 7, 1);
    drain();

    // longest window
    push(15, 63, 0);
    drain();

    // fill the queue (R8), then reset mid-flight (R9)
    push(0, 63, 0); push(1, 63, 0); push(2, 63, 0); push(3, 63, 0); push(4, 63, 0);
    @(negedge clk);
    chk(!reqReady, "R8", "reqReady with four held", int'(reqReady), 0);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    seenBefore = winSeen;
    @(negedge clk);
    chk(holdEn == 2'b00, "R9", "holdEn after mid-run reset", int'(holdEn), 0);
    chk(reqReady, "R9", "queue empty after reset", int'(reqReady), 1);
    repeat (150) @(negedge clk);
    chk(winSeen == seenBefore, "R9", "flushed requests stay silent", winSeen, seenBefore);

    // normal service resumes after reset
    @(posedge clk); #1;
    push(9, 8, 1); push(10, 7, 0);
    drain();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule